// File: doc/BRIEF.md
# Bus-Gated Shadow Count Register

This block keeps a free-running event counter and a shadow copy of it that a two-wire serial slave can shift out. The counter and the shadow both live in the counter's clock domain. The block watches the SDA and SCL bus lines through synchronizers clocked by that same clock. It refreshes the shadow on every cycle while the bus is idle, and it stops refreshing as soon as it sees a bus START. The shadow then holds one coherent count for the whole transfer, however slowly the bus master clocks it out.

A STOP condition releases the freeze, and the shadow resumes tracking the counter. A repeated START inside a transaction leaves the shadow frozen. SDA changes while SCL is low are data bits, and they never alter the gating. Address decoding and data shifting belong to the serial slave that reads `shadow_q`. They are not part of this block.

Top module: `shadow_count_gate`

## Requirements
- R1: After reset, `shadow_q` is zero and `busy` is low.
- R2: The internal counter rises by one on each clock edge where `count_en` is high and holds otherwise. While `busy` is low and no START is being detected, `shadow_q` equals the counter value from one clock edge earlier.
- R3: A START is SDA going from 1 to 0 while SCL is 1 in two consecutive synchronized samples. A START sets `busy` on the next clock edge.
- R4: Once `busy` is high, `shadow_q` does not change on any clock edge, whatever `count_en` does.
- R5: A STOP is SDA going from 0 to 1 while SCL is 1 in two consecutive synchronized samples. A STOP clears `busy` on the next edge, and refresh resumes.
- R6: A repeated START while `busy` is high keeps `busy` high and keeps `shadow_q` frozen. Only a STOP clears `busy`.
- R7: SDA changes while SCL is 0 leave `busy` unchanged, both when the bus is idle and during a transaction.
- R8: The counter and the shadow are WIDTH bits wide, and the counter wraps from all ones to zero.
- R9: With two synchronizer stages, `busy` is still low at the second clock edge after SDA falls with SCL high, and is high at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock; all state is clocked by it |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Counter increments on edges where this is high |
| sda_in | input | 1 | Bus data line level, asynchronous |
| scl_in | input | 1 | Bus clock line level, asynchronous |
| shadow_q | output | WIDTH | Shadow copy of the counter, frozen during bus transactions |
| busy | output | 1 | High from a detected START until a detected STOP |

## Verification
The assertions assume that the counter clock is much faster than the bus. Each SDA or SCL level must last long enough to pass through the synchronizers and be seen in two consecutive samples. SDA and SCL must also never change within the same sampled interval, so that a clock-line edge cannot be mistaken for a START or STOP. The stimulus meets both conditions: it changes one line at a time, on the falling clock edge, and holds each level for at least four clock cycles.

// File: rtl/shadow_count_gate.sv
module shadow_count_gate #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             sda_in,
  input  logic             scl_in,
  output logic [WIDTH-1:0] shadow_q,
  output logic             busy
);

  logic [WIDTH-1:0]       count_q;
  logic [SYNC_STAGES-1:0] sda_sync, scl_sync;
  logic                   sda_last, scl_last;
  logic                   sda_now, scl_now;
  logic                   start_seen, stop_seen, refresh;

  assign sda_now    = sda_sync[SYNC_STAGES-1];
  assign scl_now    = scl_sync[SYNC_STAGES-1];
  assign start_seen = scl_now & scl_last &  sda_last & ~sda_now;
  assign stop_seen  = scl_now & scl_last & ~sda_last &  sda_now;
  assign refresh    = ~busy & ~start_seen;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sda_sync <= '1;
          scl_sync <= '1;
        end else begin
          sda_sync <= sda_in;
          scl_sync <= scl_in;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sda_sync <= '1;
          scl_sync <= '1;
        end else begin
          sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
          scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_last <= 1'b1;
      scl_last <= 1'b1;
      busy     <= 1'b0;
    end else begin
      sda_last <= sda_now;
      scl_last <= scl_now;
      if (start_seen)     busy <= 1'b1;
      else if (stop_seen) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      shadow_q <= '0;
    end else begin
      if (count_en) count_q  <= count_q + 1'b1;
      if (refresh)  shadow_q <= count_q;
    end
  end

  // R2 R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |=> count_q == $past(count_q) + 1'b1);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> $stable(count_q));

  // R3
  start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> busy);

  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(shadow_q));

  // R5
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !busy);

  // R6
  rpt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !stop_seen |=> busy);

  // R7
  busy_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_seen && !stop_seen |=> $stable(busy));

  // R2
  idle_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start_seen |=> shadow_q == $past(count_q));

endmodule

// File: tb/shadow_count_gate_tb.sv
`timescale 1ns/1ps
module shadow_count_gate_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic count_en = 1'b0;
  logic sda = 1'b1;
  logic scl = 1'b1;
  logic [W-1:0] shadow_q;
  logic busy;

  logic [W-1:0] cnt_m = '0;
  logic [W-1:0] prev_m = '0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shadow_count_gate #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .count_en(count_en),
    .sda_in(sda), .scl_in(scl), .shadow_q(shadow_q), .busy(busy));

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt_m  <= '0;
      prev_m <= '0;
    end else begin
      prev_m <= cnt_m;
      if (count_en) cnt_m <= cnt_m + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lines(input logic d, input logic c, input int n);
    @(negedge clk);
    sda = d;
    scl = c;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(shadow_q == 0, "R1 shadow", shadow_q, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_idle_track();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(shadow_q == prev_m, "R2 track", shadow_q, prev_m);
      count_en = (i % 3 != 0);
    end
    @(negedge clk);
    count_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(shadow_q == cnt_m, "R2 hold", shadow_q, cnt_m);
  endtask

  task automatic t_start_latency();
    @(negedge clk);
    sda = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R9 early", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R9 R3 busy", busy, 1);
  endtask

  task automatic t_freeze(input int n);
    logic [W-1:0] f;
    f = shadow_q;
    count_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(shadow_q == f, "R4 frozen", shadow_q, f);
    end
    chk(cnt_m != f, "R4 counter moved", cnt_m, f);
  endtask

  task automatic t_data_bits_busy();
    logic [W-1:0] f;
    f = shadow_q;
    lines(1'b0, 1'b0, 4);
    for (int i = 0; i < 6; i++) begin
      lines(~sda, 1'b0, 4);
      chk(busy == 1'b1, "R7 busy kept", busy, 1);
      chk(shadow_q == f, "R4 frozen data", shadow_q, f);
    end
  endtask

  task automatic t_repeated_start();
    logic [W-1:0] f;
    f = shadow_q;
    lines(1'b1, 1'b0, 4);
    lines(1'b1, 1'b1, 4);
    lines(1'b0, 1'b1, 6);
    chk(busy == 1'b1, "R6 busy", busy, 1);
    chk(shadow_q == f, "R6 frozen", shadow_q, f);
    lines(1'b0, 1'b0, 4);
    chk(busy == 1'b1, "R6 still busy", busy, 1);
  endtask

  task automatic t_stop();
    lines(1'b0, 1'b0, 4);
    lines(1'b0, 1'b1, 4);
    chk(busy == 1'b1, "R5 before stop", busy, 1);
    lines(1'b1, 1'b1, 6);
    chk(busy == 1'b0, "R5 cleared", busy, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(shadow_q == prev_m, "R5 resume", shadow_q, prev_m);
    end
  endtask

  task automatic t_data_bits_idle();
    lines(1'b1, 1'b0, 4);
    for (int i = 0; i < 4; i++) begin
      lines(~sda, 1'b0, 4);
      chk(busy == 1'b0, "R7 idle", busy, 0);
      chk(shadow_q == prev_m, "R7 track", shadow_q, prev_m);
    end
    lines(1'b1, 1'b0, 4);
    lines(1'b1, 1'b1, 4);
    chk(busy == 1'b0, "R7 idle end", busy, 0);
  endtask

  task automatic t_wrap();
    count_en = 1'b1;
    repeat (300) @(negedge clk);
    chk(shadow_q == prev_m, "R8 wrap", shadow_q, prev_m);
    chk(cnt_m == W'(prev_m + 1'b1), "R8 model", cnt_m, prev_m + 1);
    count_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_track();
    t_start_latency();
    t_freeze(20);
    t_data_bits_busy();
    t_repeated_start();
    t_freeze(10);
    t_stop();
    t_data_bits_idle();
    t_wrap();
    lines(1'b0, 1'b1, 6);
    chk(busy == 1'b1, "R3 second start", busy, 1);
    t_freeze(8);
    t_stop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule